// File: doc/BRIEF.md
# Prioritized Vectored Interrupt Controller

This block collects sixteen interrupt sources, four external pins and twelve internal peripheral flags, into ten vectors. Each vector has one of three priority levels: low, high or highest. The controller presents one request to the processor, together with the entry address of the winning vector. It also reports the level now in service. A request is raised only when its priority beats everything already being serviced, so a higher-priority event can nest inside a lower one.

The processor pulses `ack` when it takes a request. That pulse marks the request's level as in service and clears any latched edge behind that vector. A pulse on `reti` retires the innermost level. The external pins can be set to detect edges or levels, with the choices depending on the pin. Pin 3 passes through a sampling filter whose tick rate is chosen by software. Peripheral flags are level inputs that the peripheral holds until software clears them.

Top module: `vec_irq_ctrl`

## Requirements
- R1: Sources map to vector indices 0..9 as follows. Vector 0 is pin 0. Vector 1 is pin 1. Vector 2 is pin 2 or flag 0. Vector 3 is pin 3 or flag 1. Vector 4 is flag 2. Vector 5 is flag 3 or flag 4. Vector 6 is flag 5. Vector 7 is flag 6. Vector 8 is flags 7 to 9. Vector 9 is flag 10 or flag 11. The entry address `irq_vec` of vector v is 03h + 8*v, which gives 03h, 0Bh, 13h, 1Bh, 23h, 2Bh, 33h, 3Bh, 43h and 4Bh.
- R2: Bit v of `vec_prio` selects the priority of vector v. For vectors 0 and 1, 0 selects high (2) and 1 selects highest (3). For vectors 2..9, 0 selects low (1) and 1 selects high (2).
- R3: `irq_req` is 1 only when some pending vector has a priority strictly above `irq_level`. Among the pending vectors of the top priority, the lowest index is offered.
- R4: Nesting and return.
  - `ack` while `irq_req` is 1 sets `irq_level` to the offered priority on the next cycle, and clears the latched pin event of that vector.
  - `reti` drops `irq_level` to the next lower level still in service. `reti` at level 0 has no effect.
  - `ack` while `irq_req` is 0 has no effect.
- R5: Pins 0 and 1 use a 2-bit mode in `ext_mode[2i+1:2i]`: 00 rising edge, 01 falling edge, 10 high level, 11 low level. In the level modes the request follows the pin without latching.
- R6: Pins 2 and 3 use the same mode field: 00 rising edge, 01 falling edge, 1x both edges.
- R7: On pins 0 to 2, a pulse one clock wide is captured.
- R8: Pin 3 is sampled on filter ticks. `flt_rate` 00 ticks every cycle, 01 every 16 cycles, and 1x every 64 cycles. A new level passes only after it has been seen on two consecutive ticks. At rate 00, a pulse 1 cycle wide is rejected and a pulse 2 cycles wide is accepted. At rate 01, 12 cycles is rejected and 40 is accepted. At rate 1x, 40 cycles is rejected and 140 is accepted.
- R9: Peripheral flags are level sources. `src_en` bits 0..3 gate pins 0..3, and bit 4+k gates flag k. A disabled source produces no request.
- R10: After reset, `irq_req` is 0 and `irq_level` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_pin | input | 4 | External interrupt pins 0..3 |
| ext_mode | input | 8 | Trigger mode, 2 bits per pin |
| flt_rate | input | 2 | Pin 3 filter tick rate |
| src_en | input | 16 | Per-source enable |
| periph_flag | input | 12 | Internal peripheral request flags |
| vec_prio | input | 10 | Per-vector priority select |
| ack | input | 1 | Processor accepts the offered request |
| reti | input | 1 | Processor returns from the innermost handler |
| irq_req | output | 1 | Request to the processor |
| irq_vec | output | 8 | Entry address of the offered vector |
| irq_level | output | 2 | Level in service (0 none, 1 low, 2 high, 3 highest) |

## Verification
On every cycle the assertions check four things:
- an accepted request raises the service level to exactly its own priority;
- a return strictly lowers a non-zero level;
- vectors 0 and 1 are never offered below high priority;
- the pin 3 filter output moves only on a tick.

Other behaviour is shown only by the bench's scenarios. These cover the source-to-vector mapping and the tie-breaking among equal priorities. They also cover each trigger mode, the pulse widths that the filter rejects or accepts at each rate, and a three-deep nest that unwinds back to a waiting low-priority request.

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl #(
  parameter int NVEC     = 10,
  parameter int NPER     = 12,
  parameter int VBASE    = 3,
  parameter int VSTEP    = 8,
  parameter int FLT_MID  = 16,
  parameter int FLT_SLOW = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       ext_pin,
  input  logic [7:0]       ext_mode,
  input  logic [1:0]       flt_rate,
  input  logic [NPER+3:0]  src_en,
  input  logic [NPER-1:0]  periph_flag,
  input  logic [NVEC-1:0]  vec_prio,
  input  logic             ack,
  input  logic             reti,
  output logic             irq_req,
  output logic [7:0]       irq_vec,
  output logic [1:0]       irq_level
);
  localparam int VW = $clog2(NVEC);
  localparam int CW = $clog2(FLT_SLOW);
  localparam logic [CW-1:0] MID_MASK = CW'(FLT_MID - 1);

  logic [3:0]      pin_q, pin_qq, cur_s, prev_s, rise, fall, det, lvl, lat, clr, ep;
  logic [CW-1:0]   cnt;
  logic            tick, smp, flt, flt_q, take;
  logic [NPER-1:0] pf;
  logic [NVEC-1:0] vp;
  logic [2:0]      isr, top;
  logic [1:0]      best, cur_lvl, p;
  logic [VW-1:0]   win;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pin_q <= '0; pin_qq <= '0;
    end else begin
      pin_q <= ext_pin; pin_qq <= pin_q;
    end

  assign tick = (flt_rate == 2'b00) ||
                (flt_rate == 2'b01 && (cnt & MID_MASK) == '0) ||
                (flt_rate[1] && cnt == '0);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cnt <= '0; smp <= 1'b0; flt <= 1'b0; flt_q <= 1'b0;
    end else begin
      cnt   <= cnt + 1'b1;
      flt_q <= flt;
      if (tick) begin
        smp <= pin_q[3];
        if (pin_q[3] == smp) flt <= pin_q[3];
      end
    end

  // R8
  flt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !tick |=> $stable(flt));

  assign cur_s  = {flt, pin_q[2:0]};
  assign prev_s = {flt_q, pin_qq[2:0]};
  assign rise   = cur_s & ~prev_s;
  assign fall   = ~cur_s & prev_s;

  always_comb begin
    logic [1:0] m;
    for (int i = 0; i < 4; i++) begin
      m = ext_mode[2*i +: 2];
      if (i < 2) begin
        det[i] = !m[1] && (m[0] ? fall[i] : rise[i]);
        lvl[i] = m[1] && (m[0] ? !pin_q[i] : pin_q[i]);
      end else begin
        det[i] = m[1] ? (rise[i] | fall[i]) : (m[0] ? fall[i] : rise[i]);
        lvl[i] = 1'b0;
      end
      clr[i] = take && (win == VW'(i));
    end
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) lat <= '0;
    else        lat <= (lat & ~clr) | (det & src_en[3:0]);

  assign ep = src_en[3:0] & (lat | lvl);
  assign pf = periph_flag & src_en[NPER+3:4];
  assign vp = {pf[10] | pf[11], |pf[9:7], pf[6], pf[5], pf[3] | pf[4], pf[2],
               ep[3] | pf[1], ep[2] | pf[0], ep[1], ep[0]};

  always_comb begin
    best = 2'd0;
    win  = '0;
    for (int v = NVEC - 1; v >= 0; v--) begin
      if (v < 2) p = vec_prio[v] ? 2'd3 : 2'd2;
      else       p = vec_prio[v] ? 2'd2 : 2'd1;
      if (vp[v] && p >= best) begin
        best = p;
        win  = VW'(v);
      end
    end
  end

  assign cur_lvl   = isr[2] ? 2'd3 : isr[1] ? 2'd2 : isr[0] ? 2'd1 : 2'd0;
  assign top       = isr[2] ? 3'b100 : isr[1] ? 3'b010 : isr[0] ? 3'b001 : 3'b000;
  assign irq_req   = best > cur_lvl;
  assign irq_vec   = 8'(VBASE + VSTEP * int'(win));
  assign irq_level = cur_lvl;
  assign take      = ack && irq_req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)    isr <= '0;
    else if (take) isr[best - 2'd1] <= 1'b1;
    else if (reti) isr <= isr & ~top;

  // R4
  ack_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> irq_level == $past(best));
  // R4
  reti_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reti && !take && irq_level != 2'd0) |=> irq_level < $past(irq_level));
  // R2
  prio_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_req && win < VW'(2)) |-> best >= 2'd2);
endmodule

// File: tb/vec_irq_ctrl_tb.sv
`timescale 1ns/1ps
module vec_irq_ctrl_tb;
  logic        clk = 0, rst_n = 0;
  logic [3:0]  ext_pin = 0;
  logic [7:0]  ext_mode = 0;
  logic [1:0]  flt_rate = 0;
  logic [15:0] src_en = 16'hFFFF;
  logic [11:0] periph_flag = 0;
  logic [9:0]  vec_prio = 0;
  logic        ack = 0, reti = 0;
  logic        irq_req;
  logic [7:0]  irq_vec;
  logic [1:0]  irq_level;
  int tests = 0, fails = 0;
  bit done = 0;

  vec_irq_ctrl u_dut (.clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .ext_mode(ext_mode),
    .flt_rate(flt_rate), .src_en(src_en), .periph_flag(periph_flag), .vec_prio(vec_prio),
    .ack(ack), .reti(reti), .irq_req(irq_req), .irq_vec(irq_vec), .irq_level(irq_level));

  always #2 clk = ~clk;

  // {flags, prio, exp_req, exp_vec}
  localparam int NT = 17;
  localparam logic [30:0] TBL [0:NT-1] = '{
    {12'h000, 10'h000, 1'b0, 8'h00},
    {12'h001, 10'h000, 1'b1, 8'h13},
    {12'h002, 10'h000, 1'b1, 8'h1B},
    {12'h004, 10'h000, 1'b1, 8'h23},
    {12'h008, 10'h000, 1'b1, 8'h2B},
    {12'h010, 10'h000, 1'b1, 8'h2B},
    {12'h020, 10'h000, 1'b1, 8'h33},
    {12'h040, 10'h000, 1'b1, 8'h3B},
    {12'h080, 10'h000, 1'b1, 8'h43},
    {12'h100, 10'h000, 1'b1, 8'h43},
    {12'h200, 10'h000, 1'b1, 8'h43},
    {12'h400, 10'h000, 1'b1, 8'h4B},
    {12'h800, 10'h000, 1'b1, 8'h4B},
    {12'h804, 10'h000, 1'b1, 8'h23},
    {12'h804, 10'h200, 1'b1, 8'h4B},
    {12'h801, 10'h200, 1'b1, 8'h4B},
    {12'h081, 10'h004, 1'b1, 8'h13}
  };

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", tag, got, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic pulse(input int idx, input int len);
    ext_pin[idx] = 1'b1;
    cyc(len);
    ext_pin[idx] = 1'b0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(1); ack = 0;
  endtask

  task automatic do_reti();
    reti = 1; cyc(1); reti = 0;
  endtask

  task automatic expect_req(input string tag, input logic [7:0] vec);
    check({tag, " req"}, irq_req, 1);
    check({tag, " vec"}, irq_vec, vec);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: got timeout expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    cyc(3);
    check("R10 reset req", irq_req, 0);
    check("R10 reset level", irq_level, 0);
    rst_n = 1;
    cyc(2);

    // R1 R2 R3 R9 table walk
    for (int k = 0; k < NT; k++) begin
      periph_flag = TBL[k][30:19];
      vec_prio    = TBL[k][18:9];
      #1;
      check($sformatf("R1/R3 row %0d req", k), irq_req, TBL[k][8]);
      if (TBL[k][8]) check($sformatf("R1/R3 row %0d vec", k), irq_vec, TBL[k][7:0]);
    end
    periph_flag = 0; vec_prio = 0;

    // R9 masked source
    periph_flag = 12'h020; src_en[9] = 0; #1;
    check("R9 masked flag", irq_req, 0);
    src_en = 16'hFFFF; periph_flag = 0;

    // R4 ack without request
    do_ack();
    check("R4 idle ack", irq_level, 0);

    // R5 R7 pin0 rising, 1-cycle pulse
    pulse(0, 1); cyc(3);
    expect_req("R7 pin0 pulse", 8'h03);
    do_ack();
    check("R4 ack level pin0 high", irq_level, 2);
    do_reti();
    check("R4 reti to 0", irq_level, 0);
    check("R4 latch cleared", irq_req, 0);

    // R5 falling
    ext_mode[1:0] = 2'b01;
    ext_pin[0] = 1; cyc(3);
    check("R5 falling ignores rise", irq_req, 0);
    ext_pin[0] = 0; cyc(3);
    expect_req("R5 falling", 8'h03);
    do_ack(); do_reti();

    // R5 high level
    ext_mode[1:0] = 2'b10;
    ext_pin[0] = 1; cyc(3);
    expect_req("R5 high level", 8'h03);
    ext_pin[0] = 0; cyc(3);
    check("R5 level released", irq_req, 0);
    ext_mode[1:0] = 2'b00;

    // R5 low level on pin1
    ext_mode[3:2] = 2'b11; cyc(3);
    expect_req("R5 low level pin1", 8'h0B);
    ext_mode[3:2] = 2'b00; cyc(3);
    check("R5 low level off", irq_req, 0);

    // R6 both edges on pin2
    ext_mode[5:4] = 2'b10;
    ext_pin[2] = 1; cyc(3);
    expect_req("R6 both rise", 8'h13);
    do_ack(); do_reti();
    check("R6 cleared", irq_req, 0);
    ext_pin[2] = 0; cyc(3);
    expect_req("R6 both fall", 8'h13);
    do_ack(); do_reti();
    ext_mode[5:4] = 2'b00;

    // R8 filter
    flt_rate = 2'b00;
    pulse(3, 1); cyc(10);
    check("R8 rate1 reject 1", irq_req, 0);
    pulse(3, 2); cyc(10);
    expect_req("R8 rate1 accept 2", 8'h1B);
    do_ack(); do_reti();
    flt_rate = 2'b01;
    pulse(3, 12); cyc(60);
    check("R8 rate16 reject 12", irq_req, 0);
    pulse(3, 40); cyc(60);
    expect_req("R8 rate16 accept 40", 8'h1B);
    do_ack(); do_reti();
    flt_rate = 2'b10;
    pulse(3, 40); cyc(200);
    check("R8 rate64 reject 40", irq_req, 0);
    pulse(3, 140); cyc(200);
    expect_req("R8 rate64 accept 140", 8'h1B);
    do_ack(); do_reti();
    flt_rate = 2'b00;

    // R3 R4 nesting
    vec_prio = 10'b00_0100_0001;
    periph_flag = 12'h004; #1;
    expect_req("R3 nest low", 8'h23);
    do_ack();
    check("R4 level low", irq_level, 1);
    periph_flag = 12'h008; #1;
    check("R3 equal not above", irq_req, 0);
    periph_flag = 12'h028; #1;
    expect_req("R3 nest high", 8'h33);
    do_ack();
    check("R4 level high", irq_level, 2);
    periph_flag = 12'h008;
    pulse(0, 1); cyc(3);
    expect_req("R2 pin0 highest", 8'h03);
    do_ack();
    check("R4 level highest", irq_level, 3);
    do_reti();
    check("R4 unwind to high", irq_level, 2);
    do_reti();
    check("R4 unwind to low", irq_level, 1);
    check("R3 waiting low held", irq_req, 0);
    do_reti();
    check("R4 unwind to none", irq_level, 0);
    expect_req("R3 waiting low offered", 8'h2B);
    periph_flag = 0;
    do_reti();
    check("R4 reti at 0", irq_level, 0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule